// File: doc/BRIEF.md
# Redundant Heartbeat Watchdog

Three redundant processors each send a heartbeat on their own stroke line. The software toggles the line at roughly 4 Hz in step with the telemetry frame, and holds it high through the idle part of each frame. This block timestamps each channel's heartbeat. It raises a single alarm line when the heartbeat pattern shows that the redundant set can no longer be trusted.

The block treats the two failure cases differently. A lone silent processor is tolerated for a long window, by default 600 seconds. That is enough time to reload it and bring it back in step with the other two at the next sync. Two or more silent processors get only a short window, by default 2 seconds. The alarm is low in normal operation. Once it rises, it stays high until reset.

Time is counted in ticks. A prescaler produces one tick every `TICK_DIV` clock cycles, so a simulation can shrink the windows without changing the logic. Each channel has a silence counter. A rising stroke clears the counter, and each tick advances it. A control section counts how many channels have passed each limit and latches the alarm.

Top module: `hb_vote_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `alarm` is low.
- R2: If every channel shows a rising stroke at least once in every window of `SHORT_TICKS` ticks, `alarm` stays low.
- R3: Only a rising transition of a stroke line clears that channel's silence count. A line sampled 0 at one clock edge and 1 at the next is a rising transition. A line held high, or falling, counts as silent.
- R4: The tick fires at the clock edges numbered `TICK_DIV`, 2·`TICK_DIV`, and so on, counting from the first edge after reset release as edge 1. A channel's silence is the number of ticks at edges after its latest rising stroke. The first count starts at reset. A tick on the same edge as a rising stroke is not counted.
- R5: A single channel whose silence exceeds `LONG_TICKS` drives `alarm` high from the next clock edge. This holds even when the other channels are healthy.
- R6: When two or more channels each have silence above `SHORT_TICKS`, `alarm` goes high at the next clock edge.
- R7: A silence of exactly `SHORT_TICKS` does not count as stopped for R6. A silence of exactly `LONG_TICKS` does not trigger R5.
- R8: Once `alarm` is high, it stays high until `rst`, whatever the stroke lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stroke | input | N_CHAN | One heartbeat line per redundant processor, synchronous to `clk` |
| alarm | output | 1 | Sticky fault indication, high when the heartbeat rules are violated |

## Verification
The alarm is due exactly one clock edge after the edge at which a silence counter passes its limit. A counter passes its limit on the tick that follows the last counted rising stroke, and ticks land on multiples of `TICK_DIV` edges. The bench keeps its own edge number and, for each channel, the tick number of that channel's latest rising stroke. From these it works out the expected alarm level after every rising edge. It compares that level with the output at the following falling edge, so every check sees the register value one edge after its cause. A directed case with all lines silent from reset pins the first trip to edge (`SHORT_TICKS`+1)·`TICK_DIV`+1.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

  // Strobes issued by the control section to the silence datapath.
  typedef struct packed {
    logic tick;    // one-cycle time base pulse
    logic freeze;  // alarm latched: hold all silence counts
  } hbwStrobe_t;

endpackage

// File: rtl/hbw_datapath.sv
module hbw_datapath
  import hbw_pkg::*;
#(
  parameter int N_CHAN      = 3,
  parameter int SHORT_TICKS = 20,
  parameter int LONG_TICKS  = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CHAN-1:0] stroke,
  input  hbwStrobe_t        strobe,
  output logic [N_CHAN-1:0] shortStop,
  output logic [N_CHAN-1:0] longStop
);

  localparam int SAT   = LONG_TICKS + 1;
  localparam int SIL_W = $clog2(SAT + 1);
  localparam logic [SIL_W-1:0] SAT_V   = SIL_W'(SAT);
  localparam logic [SIL_W-1:0] SHORT_V = SIL_W'(SHORT_TICKS);
  localparam logic [SIL_W-1:0] LONG_V  = SIL_W'(LONG_TICKS);

  logic [N_CHAN-1:0] strokePrev;
  logic [N_CHAN-1:0] rise;
  logic [SIL_W-1:0]  silence [N_CHAN];

  always_ff @(posedge clk) begin
    if (rst) strokePrev <= '0;
    else     strokePrev <= stroke;
  end

  assign rise = stroke & ~strokePrev;

  for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        silence[i] <= '0;
      end else if (!strobe.freeze) begin
        if (rise[i])
          silence[i] <= '0;
        else if (strobe.tick && silence[i] != SAT_V)
          silence[i] <= silence[i] + 1'b1;
      end
    end

    assign shortStop[i] = silence[i] > SHORT_V;
    assign longStop[i]  = silence[i] > LONG_V;

    // R7: the long limit lies above the short one
    a_r7_long_above_short: assert property (@(posedge clk) disable iff (rst)
      longStop[i] |-> shortStop[i]);

    // R4: without a tick or a rising stroke the count does not move
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
      (!strobe.tick && !rise[i]) |=> $stable(silence[i]));

    // R3: a rising stroke leaves the channel not stopped
    a_r3_rise_clears: assert property (@(posedge clk) disable iff (rst)
      (rise[i] && !strobe.freeze) |=> !shortStop[i]);
  end

endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
  import hbw_pkg::*;
#(
  parameter int N_CHAN   = 3,
  parameter int TICK_DIV = 25_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CHAN-1:0] shortStop,
  input  logic [N_CHAN-1:0] longStop,
  output hbwStrobe_t        strobe,
  output logic              alarm
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam int CNT_W = $clog2(N_CHAN + 1);

  logic [DIV_W-1:0] divCnt;
  logic             tickNow;
  logic [CNT_W-1:0] silentCnt;
  logic             multiTrip;
  logic             singleTrip;

  // time base
  assign tickNow = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst)          divCnt <= '0;
    else if (tickNow) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  // number of channels past the short limit
  always_comb begin
    silentCnt = '0;
    for (int i = 0; i < N_CHAN; i++)
      silentCnt = silentCnt + CNT_W'(shortStop[i]);
  end

  assign multiTrip  = silentCnt >= CNT_W'(2);
  assign singleTrip = |longStop;

  always_ff @(posedge clk) begin
    if (rst) alarm <= 1'b0;
    else     alarm <= alarm | multiTrip | singleTrip;
  end

  assign strobe.tick   = tickNow;
  assign strobe.freeze = alarm;

  // R8: alarm is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    alarm |=> alarm);

  // R6: two stopped channels raise the alarm on the next edge
  a_r6_multi_trip: assert property (@(posedge clk) disable iff (rst)
    ($countones(shortStop) >= 2) |=> alarm);

  // R5: any channel past the long limit raises the alarm
  a_r5_single_trip: assert property (@(posedge clk) disable iff (rst)
    (|longStop) |=> alarm);

  // R2: the alarm never rises without a cause
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> ($past(|longStop) || ($past($countones(shortStop)) >= 2)));

  // R4: ticks are isolated pulses
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (TICK_DIV > 1 && strobe.tick) |=> !strobe.tick);

endmodule

// File: rtl/hb_vote_watchdog.sv
module hb_vote_watchdog
  import hbw_pkg::*;
#(
  parameter int N_CHAN      = 3,
  parameter int TICK_DIV    = 25_000_000,
  parameter int SHORT_TICKS = 20,
  parameter int LONG_TICKS  = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CHAN-1:0] stroke,
  output logic              alarm
);

  hbwStrobe_t        strobe;
  logic [N_CHAN-1:0] shortStop;
  logic [N_CHAN-1:0] longStop;

  hbw_ctrl #(
    .N_CHAN  (N_CHAN),
    .TICK_DIV(TICK_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shortStop(shortStop),
    .longStop (longStop),
    .strobe   (strobe),
    .alarm    (alarm)
  );

  hbw_datapath #(
    .N_CHAN     (N_CHAN),
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .stroke   (stroke),
    .strobe   (strobe),
    .shortStop(shortStop),
    .longStop (longStop)
  );

endmodule

// File: tb/test_hb_vote_watchdog.sv
module test_hb_vote_watchdog;

  localparam int N = 3;
  localparam int D = 4;
  localparam int S = 3;
  localparam int L = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] stroke = '0;
  logic         alarm;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  bit    monOn  = 1'b0;

  always #2 clk = ~clk;

  hb_vote_watchdog #(
    .N_CHAN(N), .TICK_DIV(D), .SHORT_TICKS(S), .LONG_TICKS(L)
  ) i_hb_vote_watchdog (
    .clk(clk), .rst(rst), .stroke(stroke), .alarm(alarm)
  );

  // arithmetic expectation: silence after edge k = k/D - (tick number at last rise)
  int           edgeNo;
  int           riseTick [N];
  logic [N-1:0] prevS;
  logic         errExp;

  always @(posedge clk) begin
    int  nShort;
    bit  longHit;
    int  sil;
    if (rst) begin
      edgeNo = 0;
      for (int i = 0; i < N; i++) riseTick[i] = 0;
      prevS  = '0;
      errExp = 1'b0;
    end else begin
      nShort  = 0;
      longHit = 1'b0;
      for (int i = 0; i < N; i++) begin
        sil = (edgeNo / D) - riseTick[i];
        if (sil > S) nShort++;
        if (sil > L) longHit = 1'b1;
      end
      if (nShort >= 2 || longHit) errExp = 1'b1;
      edgeNo++;
      for (int i = 0; i < N; i++)
        if (stroke[i] && !prevS[i]) riseTick[i] = edgeNo / D;
      prevS = stroke;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s alarm=%0b expected=%0b at time %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (monOn) check(curReq, alarm, errExp);

  task automatic doReset();
    curReq = "R1";
    rst    = 1'b1;
    stroke = '0;
    @(negedge clk);
    monOn = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one scenario: all alive, then stop the channels in mask, then resume all
  task automatic runCase(int mask, int period, bit lvl);
    int nStop;
    nStop = $countones(mask[N-1:0]);
    doReset();
    curReq = "R2";
    for (int t = 0; t < 130; t++) begin
      if (t == 30) begin
        if (nStop == 0)      curReq = "R2";
        else if (lvl)        curReq = "R3";
        else if (period == S * D) curReq = "R7";
        else if (nStop == 1) curReq = "R5";
        else                 curReq = "R6";
      end
      if (t == 100) curReq = (nStop == 0) ? "R2" : "R8";
      for (int i = 0; i < N; i++) begin
        if (t >= 30 && t < 100 && mask[i])
          stroke[i] = lvl;
        else
          stroke[i] = ((t + 3 * i) % period) < (period / 2);
      end
      @(negedge clk);
    end
    if (nStop == 0) check("R2", alarm, 1'b0);
    else            check("R8", alarm, 1'b1);
  endtask

  initial begin
    // R1: reset state
    doReset();
    @(negedge clk);
    check("R1", alarm, 1'b0);

    // R4: all lines silent from reset, first trip due after edge (S+1)*D+1
    doReset();
    curReq = "R4";
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (n == (S + 1) * D)     check("R4", alarm, 1'b0);
      if (n == (S + 1) * D + 1) check("R4", alarm, 1'b1);
    end

    // sweep every stopped-channel subset, alive period and stopped level
    for (int p = 0; p < 3; p++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        for (int mask = 0; mask < (1 << N); mask++) begin
          runCase(mask, (p + 1) * D, lvl[0]);
        end
      end
    end

    monOn = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired, run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule